// File: doc/BRIEF.md
# Frame-Synchronized Control Register Bank

This block is a byte-wide control register file for an image sensor pipeline. A two-wire serial slave, which is not part of this block, turns bus transactions into single-cycle write and read strobes with an 8-bit address and 8-bit data. The bank keeps every register 8 bits wide. Parameters wider than a byte occupy a low/high pair of registers.

The registers fall into three update classes. Immediate registers act on the clock after they are written. Frame registers are copied from their written value into their active copy at every frame-begin pulse. Latent registers hold their old active value until software sets a commit bit. The next frame begin that follows then moves them into effect, and the commit bit reads back 1 until that has happened.

The control register at address 0x00 also carries two command bits that clear themselves. One starts an exposure change and reads busy until the exposure logic reports done. The other is a one-shot trigger. A block of read-only status registers shows values supplied by the image pipeline. The serial slave's 7-bit device address is 0x20 or 0x21, chosen by a strap input.

Top module: `frm_regbank`

## Requirements
- R1: Under reset, the control register at 0x00 holds 0x4A, timing_o holds 0x4041, exp_time_o holds 0x0000, wb_gain_o holds 0x908070 (byte i is frame register i), and lat_o holds 0x000B (byte 0 is address 0x52, byte 1 is address 0x53).
- R2: dev_addr is 0x20 when addr_strap is 0 and 0x21 when it is 1.
- R3: Immediate registers take the written value on the clock edge of the write, and the output shows it in the following cycle. These are the timing pair 0x01 (low byte) and 0x02 (high byte), the exposure pair 0x10 (low) and 0x11 (high), and bits 0, 3, 4, 5 and 6 of 0x00.
- R4: Frame registers 0x37, 0x38 and 0x39 copy their last written value into wb_gain_o bytes 0, 1 and 2 on every frame_begin edge, and at no other time. A write in the same cycle as frame_begin reaches the output only at the next frame_begin.
- R5: Latent registers 0x52 and 0x53 change lat_o only at a frame_begin edge while the commit bit was already set before that cycle. Reads of these addresses return the last written value, not the active one.
- R6: Writing 1 to bit 7 of 0x00 sets the commit bit. It reads 1 until the frame_begin edge that applies the latent values, then reads 0. A commit write in the same cycle as frame_begin is applied at the next frame_begin instead.
- R7: Writing 1 to bit 2 of 0x00 raises exp_start for exactly the following cycle and sets bit 2. Bit 2 reads 1 until an exp_done edge clears it. A new start write in the same cycle as exp_done wins, and bit 2 stays set.
- R8: Bit 1 of 0x00 is a one-shot. When it is set, slope_start is 1 for one cycle, then the bit clears. Its reset value is 1, so it fires once in the first cycle out of reset.
- R9: Addresses 0x46 to 0x4F read byte 0 to 9 of stat_i (address 0x46 + i returns stat_i[8i+7:8i]). Writes to them are ignored.
- R10: rd_data is loaded on a clock edge with rd_en high and holds otherwise. Unmapped addresses read 0x00. Writing 0 to bits 1, 2 or 7 of 0x00 does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_strap | input | 1 | Level that selects the device address LSB |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| frame_begin | input | 1 | One-cycle frame start pulse |
| exp_done | input | 1 | Exposure logic reports change finished |
| stat_i | input | 80 | Status bytes from the image pipeline |
| dev_addr | output | 7 | Serial slave device address |
| rd_data | output | 8 | Registered read data |
| ctrl_o | output | 8 | Control register as seen by hardware and software |
| timing_o | output | 16 | Active timing word |
| exp_time_o | output | 16 | Active exposure time |
| wb_gain_o | output | 24 | Active frame-register bytes |
| lat_o | output | 16 | Active latent-register bytes |
| exp_start | output | 1 | One-cycle exposure start pulse |
| slope_start | output | 1 | One-shot trigger pulse |

## Verification
The bench drives a directed sequence and then several hundred cycles of mixed random traffic. It compares every output against a reference model on every clock. The directed part places writes before, on and after frame_begin for each update class. This separates a resample on every frame from a commit-gated transfer, and an early transfer from one correctly deferred. Exposure starts with and without a coincident exp_done show whether start or completion has priority. Writes of zero to command bits and to status addresses, followed by reads, show that those writes change nothing.

// File: rtl/frm_regbank.sv
module frm_regbank #(
  parameter int STAT_N = 10,
  parameter int FRM_N  = 3,
  parameter int LAT_N  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_strap,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  input  logic                  frame_begin,
  input  logic                  exp_done,
  input  logic [8*STAT_N-1:0]   stat_i,
  output logic [6:0]            dev_addr,
  output logic [7:0]            rd_data,
  output logic [7:0]            ctrl_o,
  output logic [15:0]           timing_o,
  output logic [15:0]           exp_time_o,
  output logic [8*FRM_N-1:0]    wb_gain_o,
  output logic [8*LAT_N-1:0]    lat_o,
  output logic                  exp_start,
  output logic                  slope_start
);
  localparam int A_CTRL = 8'h00;
  localparam int A_TIM  = 8'h01;
  localparam int A_EXP  = 8'h10;
  localparam int A_FRM  = 8'h37;
  localparam int A_STAT = 8'h46;
  localparam int A_LAT  = 8'h52;

  logic [7:0] ctrl_q;
  logic       exp_go;
  logic [1:0][7:0] tim_q, exp_q;
  logic [FRM_N-1:0][7:0] frm_sh, frm_act;
  logic [LAT_N-1:0][7:0] lat_sh, lat_act;
  logic [7:0] rd_mux;

  wire wr_ctrl = wr_en && addr == 8'(A_CTRL);

  assign dev_addr    = {6'b010000, addr_strap};
  assign ctrl_o      = ctrl_q;
  assign timing_o    = {tim_q[1], tim_q[0]};
  assign exp_time_o  = {exp_q[1], exp_q[0]};
  assign wb_gain_o   = frm_act;
  assign lat_o       = lat_act;
  assign exp_start   = exp_go;
  assign slope_start = ctrl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 8'h4A;
      exp_go <= 1'b0;
    end else begin
      ctrl_q[1] <= wr_ctrl && wdata[1];
      if (wr_ctrl) begin
        ctrl_q[0]   <= wdata[0];
        ctrl_q[6:3] <= wdata[6:3];
      end
      if (wr_ctrl && wdata[2])      ctrl_q[2] <= 1'b1;
      else if (exp_done)            ctrl_q[2] <= 1'b0;
      if (wr_ctrl && wdata[7])      ctrl_q[7] <= 1'b1;
      else if (frame_begin)         ctrl_q[7] <= 1'b0;
      exp_go <= wr_ctrl && wdata[2];
    end
  end

  genvar g;
  for (g = 0; g < 2; g++) begin : g_imm
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tim_q[g] <= (g == 0) ? 8'h41 : 8'h40;
        exp_q[g] <= 8'h00;
      end else if (wr_en) begin
        if (addr == 8'(A_TIM + g)) tim_q[g] <= wdata;
        if (addr == 8'(A_EXP + g)) exp_q[g] <= wdata;
      end
    end
  end

  for (g = 0; g < FRM_N; g++) begin : g_frm
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        frm_sh[g]  <= 8'(8'h70 + 16 * g);
        frm_act[g] <= 8'(8'h70 + 16 * g);
      end else begin
        if (wr_en && addr == 8'(A_FRM + g)) frm_sh[g] <= wdata;
        if (frame_begin) frm_act[g] <= frm_sh[g];
      end
    end
  end

  for (g = 0; g < LAT_N; g++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat_sh[g]  <= (g == 0) ? 8'h0B : 8'h00;
        lat_act[g] <= (g == 0) ? 8'h0B : 8'h00;
      end else begin
        if (wr_en && addr == 8'(A_LAT + g)) lat_sh[g] <= wdata;
        if (frame_begin && ctrl_q[7]) lat_act[g] <= lat_sh[g];
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (addr == 8'(A_CTRL)) rd_mux = ctrl_q;
    for (int i = 0; i < 2; i++) begin
      if (addr == 8'(A_TIM + i)) rd_mux = tim_q[i];
      if (addr == 8'(A_EXP + i)) rd_mux = exp_q[i];
    end
    for (int i = 0; i < FRM_N; i++)
      if (addr == 8'(A_FRM + i)) rd_mux = frm_sh[i];
    for (int i = 0; i < LAT_N; i++)
      if (addr == 8'(A_LAT + i)) rd_mux = lat_sh[i];
    for (int i = 0; i < STAT_N; i++)
      if (addr == 8'(A_STAT + i)) rd_mux = stat_i[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= 8'h00;
    else if (rd_en)  rd_data <= rd_mux;
  end
endmodule

module frm_regbank_chk #(
  parameter int FRM_N = 3,
  parameter int LAT_N = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_begin,
  input logic                cmt_wr,
  input logic                shot_wr,
  input logic                pend,
  input logic                busy,
  input logic [8*FRM_N-1:0]  frm_sh,
  input logic [8*FRM_N-1:0]  wb_gain_o,
  input logic [8*LAT_N-1:0]  lat_o,
  input logic                exp_start,
  input logic                slope_start
);
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_begin && pend) |=> $stable(lat_o)); // R5
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_begin && pend && !cmt_wr) |=> !pend); // R6
  AST_FRM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_begin |=> wb_gain_o == $past(frm_sh)); // R4
  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_begin |=> $stable(wb_gain_o)); // R4
  AST_EXP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    exp_start |-> busy); // R7
  AST_SHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (slope_start && !shot_wr) |=> !slope_start); // R8
endmodule

bind frm_regbank frm_regbank_chk #(.FRM_N(FRM_N), .LAT_N(LAT_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_begin(frame_begin),
  .cmt_wr(wr_en && addr == 8'h00 && wdata[7]),
  .shot_wr(wr_en && addr == 8'h00 && wdata[1]),
  .pend(ctrl_o[7]), .busy(ctrl_o[2]), .frm_sh(frm_sh),
  .wb_gain_o(wb_gain_o), .lat_o(lat_o),
  .exp_start(exp_start), .slope_start(slope_start));

// File: tb/frm_regbank_tb_top.sv
module frm_regbank_tb_top;
  logic clk = 0;
  logic rst_n = 0, addr_strap = 1, wr_en = 0, rd_en = 0, frame_begin = 0, exp_done = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [79:0] stat_i = 80'h0123456789ABCDEF5A3C;
  logic [6:0] dev_addr;
  logic [7:0] rd_data, ctrl_o;
  logic [15:0] timing_o, exp_time_o, lat_o;
  logic [23:0] wb_gain_o;
  logic exp_start, slope_start;

  int tests = 0, fails = 0;
  bit cmp_on = 0, done = 0;

  always #2 clk = ~clk;

  frm_regbank dut_i (.*);

  // reference model
  logic [7:0] m_ctrl, m_rd, m_tim[2], m_exp[2], m_fsh[3], m_fact[3], m_lsh[2], m_lact[2];
  bit m_go;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h01 || a == 8'h02) return m_tim[a - 8'h01];
    if (a == 8'h10 || a == 8'h11) return m_exp[a - 8'h10];
    if (a >= 8'h37 && a <= 8'h39) return m_fsh[a - 8'h37];
    if (a >= 8'h46 && a <= 8'h4F) return stat_i[8*(a - 8'h46) +: 8];
    if (a == 8'h52 || a == 8'h53) return m_lsh[a - 8'h52];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h4A; m_rd = 0; m_go = 0;
      m_tim[0] = 8'h41; m_tim[1] = 8'h40; m_exp[0] = 0; m_exp[1] = 0;
      for (int i = 0; i < 3; i++) begin m_fsh[i] = 8'h70 + 8'(16*i); m_fact[i] = m_fsh[i]; end
      m_lsh[0] = 8'h0B; m_lsh[1] = 0; m_lact[0] = 8'h0B; m_lact[1] = 0;
    end else begin
      logic [7:0] n;
      bit wc;
      wc = wr_en && addr == 8'h00;
      if (rd_en) m_rd = m_read(addr);
      n = m_ctrl;
      n[1] = wc && wdata[1];
      if (wc) begin n[0] = wdata[0]; n[6:3] = wdata[6:3]; end
      if (wc && wdata[2]) n[2] = 1; else if (exp_done) n[2] = 0;
      if (frame_begin && m_ctrl[7]) for (int i = 0; i < 2; i++) m_lact[i] = m_lsh[i];
      if (wc && wdata[7]) n[7] = 1; else if (frame_begin) n[7] = 0;
      if (frame_begin) for (int i = 0; i < 3; i++) m_fact[i] = m_fsh[i];
      m_go = wc && wdata[2];
      if (wr_en) begin
        if (addr == 8'h01 || addr == 8'h02) m_tim[addr - 8'h01] = wdata;
        if (addr == 8'h10 || addr == 8'h11) m_exp[addr - 8'h10] = wdata;
        if (addr >= 8'h37 && addr <= 8'h39) m_fsh[addr - 8'h37] = wdata;
        if (addr == 8'h52 || addr == 8'h53) m_lsh[addr - 8'h52] = wdata;
      end
      m_ctrl = n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R3/R6/R7/R8 ctrl_o", ctrl_o, m_ctrl);
    chk("R3 timing_o", timing_o, {m_tim[1], m_tim[0]});
    chk("R3 exp_time_o", exp_time_o, {m_exp[1], m_exp[0]});
    chk("R4 wb_gain_o", wb_gain_o, {m_fact[2], m_fact[1], m_fact[0]});
    chk("R5 lat_o", lat_o, {m_lact[1], m_lact[0]});
    chk("R7 exp_start", exp_start, m_go);
    chk("R8 slope_start", slope_start, m_ctrl[1]);
    chk("R5/R9/R10 rd_data", rd_data, m_rd);
    chk("R2 dev_addr", dev_addr, {6'b010000, addr_strap});
  end

  task automatic cyc(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d,
                     input bit fb = 0, input bit dn = 0);
    wr_en = w; rd_en = r; addr = a; wdata = d; frame_begin = fb; exp_done = dn;
    @(negedge clk);
    wr_en = 0; rd_en = 0; frame_begin = 0; exp_done = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(input logic [7:0] a); cyc(0, 1, a, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0); endtask
  task automatic fb(); cyc(0, 0, 0, 0, 1, 0); endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1 reset values while reset is held
    chk("R1 ctrl reset", ctrl_o, 8'h4A);
    chk("R1 timing reset", timing_o, 16'h4041);
    chk("R1 exp reset", exp_time_o, 16'h0000);
    chk("R1 wb reset", wb_gain_o, 24'h908070);
    chk("R1 lat reset", lat_o, 16'h000B);
    chk("R2 strap 1", dev_addr, 7'h21);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);                      // r8_ reset one-shot fired and cleared
    addr_strap = 0; idle(1);
    chk("R2 strap 0", dev_addr, 7'h20);
    // R3 immediate
    wr(8'h01, 8'h55); wr(8'h02, 8'h12); wr(8'h10, 8'h34); wr(8'h11, 8'h01);
    wr(8'h00, 8'h79);                    // bits 0,3..6 ; also r10_ zero to bit 7
    rd(8'h01); rd(8'h11); rd(8'h00);
    // R4 frame registers
    wr(8'h37, 8'h11); wr(8'h39, 8'hEE); idle(2); fb();
    cyc(1, 0, 8'h38, 8'h22, 1, 0);       // same-cycle write deferred
    idle(1); fb(); rd(8'h38);
    // R5 / R6 latent
    wr(8'h52, 8'h1F); rd(8'h52); fb(); idle(1);
    wr(8'h00, 8'h80); idle(2); rd(8'h00); fb(); rd(8'h00);
    wr(8'h53, 8'h44);
    cyc(1, 0, 8'h00, 8'h80, 1, 0);       // commit on frame_begin: deferred
    rd(8'h00); idle(1); fb(); rd(8'h00);
    // R7 exposure
    wr(8'h00, 8'h04); idle(3); rd(8'h00); cyc(0, 0, 0, 0, 0, 1); rd(8'h00);
    wr(8'h00, 8'h04); cyc(1, 0, 8'h00, 8'h04, 0, 1); rd(8'h00);
    cyc(0, 0, 0, 0, 0, 1); wr(8'h00, 8'h00); rd(8'h00);
    // R8 one-shot
    wr(8'h00, 8'h02); idle(2); wr(8'h00, 8'h02); wr(8'h00, 8'h02); idle(1);
    // R9 status, R10 unmapped
    for (int i = 0; i < 10; i++) rd(8'h46 + 8'(i));
    wr(8'h46, 8'hFF); wr(8'h4F, 8'h00); rd(8'h46); rd(8'h4F);
    stat_i = 80'hFEDCBA98765432100F1E; rd(8'h47);
    rd(8'h70); rd(8'hFF); idle(2);
    // mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      case ($urandom_range(0, 9))
        0: a = 8'h00; 1: a = 8'h01; 2: a = 8'h11; 3: a = 8'h37; 4: a = 8'h39;
        5: a = 8'h52; 6: a = 8'h53; 7: a = 8'h46 + 8'($urandom_range(0, 9));
        8: a = 8'h60; default: a = 8'h38;
      endcase
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, 8'($urandom),
          $urandom_range(0, 6) == 0, $urandom_range(0, 4) == 0);
    end
    idle(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule